// File: doc/BRIEF.md
# Dual-Master Peripheral Cycle Engine

This block lets two independent requesters share one narrow external peripheral bus with an 8-bit data path. One requester is a host I/O port that presents a 16-bit I/O address. The other is a serial-management command path that presents a command byte. The engine picks one requester, decodes its address or command into one of four chip selects and a 4-bit low address, and then runs a single read or write cycle on the peripheral pins. The setup, strobe-width and hold phases of that cycle each have a programmable length.

Arbitration is first come, first served, and it is keyed on the rising edge of a request. A request that arrives while the engine is busy is dropped, not queued. A requester learns that it won only through its grant output. Once granted, it keeps its request high until it sees the done pulse. It then lowers the request before it raises another one. The interface has no other back-pressure: the grant is the acceptance. The payload (address or command, write flag, write data) is captured on the accepting clock edge. It may change after the grant appears. Read data is returned on a shared output and is valid from the done pulse onward.

Host selects are placed by the `HOST_BASES` parameter. Each one covers a window of 16 consecutive ports. Management selects are chosen by the upper nibble of each byte in `MGMT_KEYS`.

Top module: `pcyc_engine`

## Requirements
- R1: After reset, both grants and `done` are 0, `rdata` is 0x00, all `pb_cs_n` bits are 1, `pb_rd_n` and `pb_wr_n` are 1, and `pb_doe` is 0.
- R2: A request is considered only in the clock in which it rises while the engine is idle. The winner's grant is high in the next cycle. If both requests rise in the same clock, the host wins.
- R3: A request that rises while the engine is busy, including in the done cycle, is dropped for good. Holding it high afterwards yields no grant. Lowering and re-raising it while idle gets the grant.
- R4: Exactly one grant is high from the cycle after acceptance through the done cycle, and it falls in the cycle after done.
- R5: A host cycle whose address bits [15:4] equal bits [15:4] of select i's base drives `pb_cs_n[i]` low (the lowest index wins on overlap) and drives `pb_addr` with address bits [3:0].
- R6: A management cycle whose command bits [7:4] equal the upper nibble of select i's key drives `pb_cs_n[i]` low (the lowest index wins) and drives `pb_addr` with command bits [3:0].
- R7: A cycle with no matching select produces no chip select, no strobe and no data drive. `done` follows in the cycle after acceptance, and `rdata` becomes 0xFF.
- R8: With phase counts S, W and H, the chip select and address are active for S+1 cycles before the strobe, the strobe is low for W+1 cycles, the select and address stay active for H+1 cycles after the strobe, and `done` is high in the next cycle. The address is stable while the select is active.
- R9: A read returns in `rdata` the `pb_din` value present in the last strobe-low cycle. A write drives `pb_dout` with the write data and holds `pb_doe` high for the whole active period.
- R10: `done` is a single-cycle pulse, and no chip select is active during it.
- R11: A read (write flag 0) pulses only `pb_rd_n`. A write (write flag 1) pulses only `pb_wr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | CNT_W | Setup count S (phase lasts S+1 clocks) |
| cfg_width | input | CNT_W | Strobe count W (phase lasts W+1 clocks) |
| cfg_hold | input | CNT_W | Hold count H (phase lasts H+1 clocks) |
| h_req | input | 1 | Host request; the rising edge asks for the bus |
| h_addr | input | HADDR_W | Host I/O address |
| h_we | input | 1 | Host write flag (1 = write) |
| h_wdata | input | 8 | Host write data |
| h_gnt | output | 1 | Host owns the engine |
| m_req | input | 1 | Management request; the rising edge asks for the bus |
| m_cmd | input | 8 | Management command byte |
| m_we | input | 1 | Management write flag (1 = write) |
| m_wdata | input | 8 | Management write data |
| m_gnt | output | 1 | Management path owns the engine |
| done | output | 1 | One-cycle end-of-cycle pulse |
| rdata | output | 8 | Read data for the winner |
| pb_addr | output | 4 | Peripheral low address |
| pb_cs_n | output | 4 | Active-low chip selects |
| pb_rd_n | output | 1 | Active-low read strobe |
| pb_wr_n | output | 1 | Active-low write strobe |
| pb_dout | output | 8 | Peripheral write data |
| pb_doe | output | 1 | Drive enable for `pb_dout` |
| pb_din | input | 8 | Peripheral read data |

## Verification
A phase counter that is loaded or decremented wrongly shows up at once as a setup, strobe or hold phase of the wrong length. The bench counts each phase in every cycle against S+1, W+1 and H+1. A corrupted owner or pending-edge state appears as a wrong or missing grant in the first cycle after the request rises, or as a grant given to a request that should have been dropped within the three idle cycles observed afterwards. A wrong decode shows on `pb_cs_n` and `pb_addr` from the first active cycle. A capture made in the wrong cycle only shows in `rdata` at the done pulse.

// File: rtl/pcyc_pkg.sv
package pcyc_pkg;
  localparam int PB_DW = 8;
  localparam int PB_AW = 4;
  localparam int CS_N  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_DONE
  } phase_e;

  typedef enum logic {
    SRC_MGMT = 1'b0,
    SRC_HOST = 1'b1
  } src_e;

  typedef struct packed {
    src_e             owner;
    logic             hit;
    logic             we;
    logic [CS_N-1:0]  sel;
    logic [PB_AW-1:0] xa;
    logic [PB_DW-1:0] wdata;
  } cyc_t;
endpackage

// File: rtl/pcyc_arb.sv
module pcyc_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic h_req,
  input  logic m_req,
  input  logic idle,
  output logic accept,
  output logic host_win
);
  logic h_q, m_q;
  logic h_rise, m_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= 1'b0;
      m_q <= 1'b0;
    end else begin
      h_q <= h_req;
      m_q <= m_req;
    end
  end

  assign h_rise   = h_req & ~h_q;
  assign m_rise   = m_req & ~m_q;
  assign accept   = idle & (h_rise | m_rise);
  assign host_win = h_rise;
endmodule

// File: rtl/pcyc_decode.sv
module pcyc_decode
  import pcyc_pkg::*;
#(
  parameter int IN_W = 16,
  parameter logic [CS_N*IN_W-1:0] KEYS = '0
) (
  input  logic [IN_W-1:0]  key,
  output logic             hit,
  output logic [CS_N-1:0]  sel,
  output logic [PB_AW-1:0] xa
);
  localparam int TAG_W = IN_W - PB_AW;

  logic [CS_N-1:0] raw;

  for (genvar i = 0; i < CS_N; i++) begin : g_cmp
    assign raw[i] = (key[IN_W-1:PB_AW] == KEYS[i*IN_W+PB_AW +: TAG_W]);
  end

  always_comb begin
    sel = '0;
    for (int i = CS_N - 1; i >= 0; i--) begin
      if (raw[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
  end

  assign hit = |raw;
  assign xa  = key[PB_AW-1:0];
endmodule

// File: rtl/pcyc_seq.sv
module pcyc_seq
  import pcyc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  cyc_t             cyc_in,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic [PB_DW-1:0] pb_din,
  output logic             idle,
  output logic             busy_host,
  output logic             busy_mgmt,
  output logic             done,
  output logic [PB_DW-1:0] rdata,
  output logic [PB_AW-1:0] pb_addr,
  output logic [CS_N-1:0]  pb_cs_n,
  output logic             pb_rd_n,
  output logic             pb_wr_n,
  output logic [PB_DW-1:0] pb_dout,
  output logic             pb_doe
);
  phase_e           st;
  logic [CNT_W-1:0] cnt;
  cyc_t             cyc;
  logic             active, strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      cyc   <= '0;
      rdata <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          cyc <= cyc_in;
          if (cyc_in.hit) begin
            st  <= ST_SETUP;
            cnt <= cfg_setup;
          end else begin
            st    <= ST_DONE;
            rdata <= '1;
          end
        end
        ST_SETUP: if (cnt == '0) begin
          st  <= ST_STROBE;
          cnt <= cfg_width;
        end else cnt <= cnt - 1'b1;
        ST_STROBE: if (cnt == '0) begin
          st  <= ST_HOLD;
          cnt <= cfg_hold;
          if (!cyc.we) rdata <= pb_din;
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cnt == '0) st <= ST_DONE;
                 else cnt <= cnt - 1'b1;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (st == ST_IDLE);
  assign active    = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
  assign strobe    = (st == ST_STROBE);
  assign busy_host = !idle && (cyc.owner == SRC_HOST);
  assign busy_mgmt = !idle && (cyc.owner == SRC_MGMT);
  assign done      = (st == ST_DONE);
  assign pb_cs_n   = active ? ~cyc.sel : '1;
  assign pb_addr   = active ? cyc.xa : '0;
  assign pb_rd_n   = !(strobe && !cyc.we);
  assign pb_wr_n   = !(strobe && cyc.we);
  assign pb_doe    = active && cyc.we;
  assign pb_dout   = pb_doe ? cyc.wdata : '0;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pb_rd_n && !pb_wr_n));
  // R8
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pb_rd_n || !pb_wr_n) |-> (pb_cs_n != '1));
  // R5
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pb_cs_n));
  // R8
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_cs_n != '1) |=> ((pb_cs_n == '1) || $stable(pb_addr)));
  // R10
  no_cs_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pb_cs_n == '1));
endmodule

// File: rtl/pcyc_engine.sv
module pcyc_engine
  import pcyc_pkg::*;
#(
  parameter int HADDR_W = 16,
  parameter int CNT_W   = 4,
  parameter logic [CS_N*HADDR_W-1:0] HOST_BASES =
    {16'h0FF0, 16'h0310, 16'h0300, 16'h0080},
  parameter logic [CS_N*8-1:0] MGMT_KEYS = {8'hB0, 8'hA0, 8'h90, 8'h80}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_setup,
  input  logic [CNT_W-1:0]   cfg_width,
  input  logic [CNT_W-1:0]   cfg_hold,
  input  logic               h_req,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic               h_we,
  input  logic [PB_DW-1:0]   h_wdata,
  output logic               h_gnt,
  input  logic               m_req,
  input  logic [7:0]         m_cmd,
  input  logic               m_we,
  input  logic [PB_DW-1:0]   m_wdata,
  output logic               m_gnt,
  output logic               done,
  output logic [PB_DW-1:0]   rdata,
  output logic [PB_AW-1:0]   pb_addr,
  output logic [CS_N-1:0]    pb_cs_n,
  output logic               pb_rd_n,
  output logic               pb_wr_n,
  output logic [PB_DW-1:0]   pb_dout,
  output logic               pb_doe,
  input  logic [PB_DW-1:0]   pb_din
);
  logic             idle, accept, host_win;
  logic             h_hit, m_hit;
  logic [CS_N-1:0]  h_sel, m_sel;
  logic [PB_AW-1:0] h_xa, m_xa;
  cyc_t             cyc_in;

  pcyc_arb u_arb (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .m_req(m_req),
    .idle(idle), .accept(accept), .host_win(host_win)
  );

  pcyc_decode #(.IN_W(HADDR_W), .KEYS(HOST_BASES)) u_hdec (
    .key(h_addr), .hit(h_hit), .sel(h_sel), .xa(h_xa)
  );

  pcyc_decode #(.IN_W(8), .KEYS(MGMT_KEYS)) u_mdec (
    .key(m_cmd), .hit(m_hit), .sel(m_sel), .xa(m_xa)
  );

  always_comb begin
    if (host_win) begin
      cyc_in = '{owner: SRC_HOST, hit: h_hit, we: h_we, sel: h_sel,
                 xa: h_xa, wdata: h_wdata};
    end else begin
      cyc_in = '{owner: SRC_MGMT, hit: m_hit, we: m_we, sel: m_sel,
                 xa: m_xa, wdata: m_wdata};
    end
  end

  pcyc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cyc_in(cyc_in),
    .cfg_setup(cfg_setup), .cfg_width(cfg_width), .cfg_hold(cfg_hold),
    .pb_din(pb_din), .idle(idle), .busy_host(h_gnt), .busy_mgmt(m_gnt),
    .done(done), .rdata(rdata), .pb_addr(pb_addr), .pb_cs_n(pb_cs_n),
    .pb_rd_n(pb_rd_n), .pb_wr_n(pb_wr_n), .pb_dout(pb_dout), .pb_doe(pb_doe)
  );

  // R4
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_gnt && m_gnt));
  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_gnt || m_gnt) && !done) |=> (h_gnt || m_gnt));
  // R2
  host_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && host_win) |=> h_gnt);
  // R7
  miss_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cyc_in.hit) |=> (done && rdata == '1));
endmodule

// File: tb/pcyc_engine_bench.sv
module pcyc_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_setup = '0, cfg_width = '0, cfg_hold = '0;
  logic h_req = 1'b0, h_we = 1'b0, m_req = 1'b0, m_we = 1'b0;
  logic [15:0] h_addr = '0;
  logic [7:0] h_wdata = '0, m_cmd = '0, m_wdata = '0, pb_din = '0;
  logic h_gnt, m_gnt, done, pb_rd_n, pb_wr_n, pb_doe;
  logic [7:0] rdata, pb_dout;
  logic [3:0] pb_addr, pb_cs_n;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pcyc_engine u_pcyc_engine (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_width(cfg_width),
    .cfg_hold(cfg_hold), .h_req(h_req), .h_addr(h_addr), .h_we(h_we),
    .h_wdata(h_wdata), .h_gnt(h_gnt), .m_req(m_req), .m_cmd(m_cmd),
    .m_we(m_we), .m_wdata(m_wdata), .m_gnt(m_gnt), .done(done),
    .rdata(rdata), .pb_addr(pb_addr), .pb_cs_n(pb_cs_n), .pb_rd_n(pb_rd_n),
    .pb_wr_n(pb_wr_n), .pb_dout(pb_dout), .pb_doe(pb_doe), .pb_din(pb_din)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // src, addr, cmd, we, wdata, din, S, W, H, cs index (4 = none), xa
  localparam int NV = 10;
  localparam logic [60:0] VEC [NV] = '{
    {1'b1, 16'h0083, 8'h00, 1'b0, 8'h00, 8'h5A, 4'd0, 4'd0, 4'd0, 3'd0, 4'h3},
    {1'b1, 16'h030C, 8'h00, 1'b1, 8'hA5, 8'h00, 4'd2, 4'd3, 4'd1, 3'd1, 4'hC},
    {1'b1, 16'h031F, 8'h00, 1'b0, 8'h00, 8'h3C, 4'd1, 4'd2, 4'd2, 3'd2, 4'hF},
    {1'b1, 16'h0FF0, 8'h00, 1'b0, 8'h00, 8'hC3, 4'd3, 4'd1, 4'd0, 3'd3, 4'h0},
    {1'b1, 16'h0400, 8'h00, 1'b0, 8'h00, 8'h12, 4'd2, 4'd2, 4'd2, 3'd4, 4'h0},
    {1'b0, 16'h0000, 8'h97, 1'b0, 8'h00, 8'h11, 4'd1, 4'd1, 4'd1, 3'd1, 4'h7},
    {1'b0, 16'h0000, 8'hB2, 1'b1, 8'h22, 8'h00, 4'd0, 4'd4, 4'd3, 3'd3, 4'h2},
    {1'b0, 16'h0000, 8'h85, 1'b0, 8'h00, 8'h77, 4'd5, 4'd0, 4'd2, 3'd0, 4'h5},
    {1'b0, 16'h0000, 8'h3F, 1'b0, 8'h00, 8'h99, 4'd1, 4'd1, 4'd1, 3'd4, 4'h0},
    {1'b1, 16'h0080, 8'h00, 1'b1, 8'h6E, 8'h00, 4'd0, 4'd0, 4'd0, 3'd0, 4'h0}
  };

  task automatic run_txn(input logic [60:0] v);
    logic is_host, we, hit, g, oth, stb, wrong, seen, got_done;
    logic [7:0] wd, din, rd_at_done;
    logic [3:0] s, w, h, xa, exp_csn, cs_at_done;
    logic [2:0] csx;
    int npre, nstr, npost, bad_cs, bad_xa, bad_stb, bad_gnt, bad_dout;
    is_host = v[60]; we = v[35]; wd = v[34:27]; din = v[26:19];
    s = v[18:15]; w = v[14:11]; h = v[10:7]; csx = v[6:4]; xa = v[3:0];
    hit = (csx != 3'd4);
    exp_csn = hit ? ~(4'b0001 << csx) : 4'hF;
    npre = 0; nstr = 0; npost = 0; bad_cs = 0; bad_xa = 0; bad_stb = 0;
    bad_gnt = 0; bad_dout = 0; seen = 0; got_done = 0;
    rd_at_done = '0; cs_at_done = '0;
    @(negedge clk);
    cfg_setup = s; cfg_width = w; cfg_hold = h; pb_din = din;
    if (is_host) begin
      h_addr = v[59:44]; h_we = we; h_wdata = wd; h_req = 1'b1;
    end else begin
      m_cmd = v[43:36]; m_we = we; m_wdata = wd; m_req = 1'b1;
    end
    for (int k = 0; k < 80 && !got_done; k++) begin
      @(negedge clk);
      g   = is_host ? h_gnt : m_gnt;
      oth = is_host ? m_gnt : h_gnt;
      if (!g || oth) bad_gnt++;
      if (done) begin
        got_done = 1; rd_at_done = rdata; cs_at_done = pb_cs_n;
      end else begin
        if (pb_cs_n != exp_csn) bad_cs++;
        if (pb_addr != xa) bad_xa++;
        stb   = we ? !pb_wr_n : !pb_rd_n;
        wrong = we ? !pb_rd_n : !pb_wr_n;
        if (wrong) bad_stb++;
        if (stb) begin nstr++; seen = 1; end
        else if (!seen) npre++;
        else npost++;
        if (we && (!pb_doe || pb_dout != wd)) bad_dout++;
      end
    end
    check(got_done, "R8 done reached", 32'(got_done), 1);
    check(bad_gnt == 0, "R4 grant held", bad_gnt, 0);
    check(bad_cs == 0, is_host ? "R5 host chip select" : "R6 mgmt chip select", bad_cs, 0);
    check(bad_xa == 0, is_host ? "R5 host low address" : "R6 mgmt low address", bad_xa, 0);
    check(bad_stb == 0, "R11 strobe type", bad_stb, 0);
    check(cs_at_done == 4'hF, "R10 no select at done", cs_at_done, 4'hF);
    if (hit) begin
      check(npre == int'(s) + 1, "R8 setup length", npre, s + 1);
      check(nstr == int'(w) + 1, "R8 strobe length", nstr, w + 1);
      check(npost == int'(h) + 1, "R8 hold length", npost, h + 1);
      if (we) check(bad_dout == 0, "R9 write data drive", bad_dout, 0);
      else    check(rd_at_done == din, "R9 read data", rd_at_done, din);
    end else begin
      check(npre + nstr + npost == 0, "R7 miss is immediate", npre + nstr + npost, 0);
      check(rd_at_done == 8'hFF, "R7 miss read value", rd_at_done, 8'hFF);
    end
    @(negedge clk);
    check(!done, "R10 done single cycle", 32'(done), 0);
    check(!h_gnt && !m_gnt, "R4 grant released", {h_gnt, m_gnt}, 0);
    h_req = 1'b0; m_req = 1'b0;
  endtask

  task automatic wait_done_watch_m(output int m_seen);
    m_seen = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (m_gnt) m_seen++;
      if (done) break;
    end
  endtask

  initial begin
    int ms;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!h_gnt && !m_gnt && !done, "R1 grants/done", {h_gnt, m_gnt, done}, 0);
    check(pb_cs_n == 4'hF && pb_rd_n && pb_wr_n && !pb_doe, "R1 bus idle",
          {pb_cs_n, pb_rd_n, pb_wr_n, pb_doe}, 32'h7E);
    check(rdata == 8'h00, "R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_txn(VEC[i]);

    // R2: both requests rise together; host wins
    @(negedge clk);
    cfg_setup = 4'd2; cfg_width = 4'd2; cfg_hold = 4'd2;
    h_addr = 16'h0081; h_we = 1'b0; m_cmd = 8'h91; m_we = 1'b0;
    h_req = 1'b1; m_req = 1'b1;
    @(negedge clk);
    check(h_gnt && !m_gnt, "R2 host wins tie", {h_gnt, m_gnt}, 2'b10);
    wait_done_watch_m(ms);
    check(ms == 0, "R3 busy loser no grant", ms, 0);
    h_req = 1'b0;
    ms = 0;
    repeat (3) begin @(negedge clk); if (m_gnt) ms++; end
    check(ms == 0, "R3 held loser stays dropped", ms, 0);
    m_req = 1'b0;

    // R3: request rising in the done cycle is dropped; re-raise wins
    @(negedge clk);
    h_req = 1'b1;
    wait_done_watch_m(ms);
    h_req = 1'b0; m_req = 1'b1;
    ms = 0;
    repeat (3) begin @(negedge clk); if (m_gnt) ms++; end
    check(ms == 0, "R3 rise in done dropped", ms, 0);
    m_req = 1'b0;
    @(negedge clk);
    m_req = 1'b1;
    @(negedge clk);
    check(m_gnt && !h_gnt, "R3 re-raise granted", {h_gnt, m_gnt}, 2'b01);
    wait_done_watch_m(ms);
    m_req = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule